// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block drives one output pin with a pulse-width modulated waveform. A single 32-bit control word, written and read through a plain strobe port, holds a run bit, an 8-bit prescale value R and an 8-bit duty code N. Every period has 256 equal steps. Each step lasts R input clocks, and R = 0 stands for 256. The duty code counts the low steps, not the high ones. The pin is high for the first 256 − N steps of a period and low for the rest. Code 0 keeps the pin low.

Software changes the waveform by writing the whole word. A new prescale or duty value written while the channel runs is held back until the current period ends, so a partial period never produces a stray pulse. While the run bit is clear the pin stays low and both counters stay at zero. Setting the run bit starts a fresh period on the next cycle.

Top module: `pwm8_prescaled`

## Requirements
- R1: Control word layout: bit 31 is the run bit, bits 15:8 hold the prescale value R, and bits 7:0 hold the duty code N. A read request returns the stored word on `reg_rdata` one cycle later. Bits 30:16 always read as zero, whatever was written to them. A read in the same cycle as a write returns the word as it was before that write.
- R2: After reset the control word is zero and `pwm_out` is low.
- R3: While running, one period lasts 256 × R clocks, and R = 0 counts as 256.
- R4: While running with a duty code N from 1 to 255, `pwm_out` is high for the first (256 − N) × R clocks of each period and low for the remaining N × R clocks.
- R5: A duty code of 0 keeps `pwm_out` low for the whole period.
- R6: While the run bit is clear, `pwm_out` is low and the step and prescale counters stay at zero. Clearing the run bit leaves the stored R and N unchanged.
- R7: A write that sets the run bit while the channel is stopped starts a period in the very next cycle. `pwm_out` is high in that cycle if N ≠ 0.
- R8: R and N written while the channel is running take effect only when the current period ends.
- R9: While running, the step counter moves only by +1, modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read request |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| pwm_out | output | 1 | Modulated output pin |

## Verification
A fault in the step or prescale counter shows up as a wrong high-clock count or a shifted rising edge within one period: at most 256 clocks at R = 1 and 65,536 clocks at R = 0. A shadow register that reloads too early shows up as a wrong high time in the period that is still running when a new duty code is written. A fault in the stopped state shows up in the first cycle at the pin, either as a high level while stopped or as a late first high level after the run bit is set. A layout fault in the control word shows up on the read that follows the write.

// File: rtl/pwm8_prescaled.sv
module pwm8_prescaled (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pwm_out
);
  localparam int EN_BIT = 31;
  localparam int W      = 8;

  logic         ctrl_en;
  logic [W-1:0] ctrl_rld, ctrl_duty;
  logic [W-1:0] act_rld, act_duty;
  logic [W-1:0] step, pre;

  wire          nxt_en   = reg_wr ? reg_wdata[EN_BIT] : ctrl_en;
  wire  [W-1:0] nxt_rld  = reg_wr ? reg_wdata[2*W-1:W] : ctrl_rld;
  wire  [W-1:0] nxt_duty = reg_wr ? reg_wdata[W-1:0]   : ctrl_duty;

  wire  [W-1:0] pre_last   = act_rld - 1'b1;
  wire          step_done  = (pre == pre_last);
  wire          period_end = step_done && (&step);
  wire  [W:0]   hi_sum     = {1'b0, step} + {1'b0, act_duty};

  assign pwm_out = ctrl_en && (act_duty != '0) && !hi_sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_rld  <= '0;
      ctrl_duty <= '0;
    end else if (reg_wr) begin
      ctrl_en   <= reg_wdata[EN_BIT];
      ctrl_rld  <= reg_wdata[2*W-1:W];
      ctrl_duty <= reg_wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= {ctrl_en, 15'd0, ctrl_rld, ctrl_duty};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      step <= '0;
    end else if (!ctrl_en || !nxt_en) begin
      pre  <= '0;
      step <= '0;
    end else if (step_done) begin
      pre  <= '0;
      step <= step + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rld  <= '0;
      act_duty <= '0;
    end else if (!ctrl_en || period_end) begin
      act_rld  <= nxt_rld;
      act_duty <= nxt_duty;
    end
  end
endmodule

// File: rtl/pwm8_prescaled_chk.sv
module pwm8_prescaled_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [7:0]  step,
  input logic [7:0]  pre,
  input logic [7:0]  act_duty,
  input logic [31:0] reg_rdata,
  input logic        pwm_out
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30:16] == 15'd0);

  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  // R6
  off_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (step == 8'd0 && pre == 8'd0));

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == 8'd0) |-> !pwm_out);

  // R7
  first_step_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == 8'd0 && act_duty != 8'd0) |-> pwm_out);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (step != 8'd0 || pre != 8'd0)) |-> $stable(act_duty));

  // R9
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(step)) |-> (step == $past(step) + 8'd1));
endmodule

bind pwm8_prescaled pwm8_prescaled_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (ctrl_en),
  .step     (step),
  .pre      (pre),
  .act_duty (act_duty),
  .reg_rdata(reg_rdata),
  .pwm_out  (pwm_out)
);

// File: tb/pwm8_prescaled_tb.sv
module pwm8_prescaled_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm8_prescaled u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] v);
    reg_wdata = v;
    reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(output logic [31:0] v);
    reg_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic stop_ch();
    wr_reg(32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R2", "out after reset", int'(pwm_out), 0);
    rd_reg(v);
    chk("R2", "word after reset", int'(v), 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr_reg(32'h7FFF_ABCD);
    rd_reg(v);
    chk("R1", "reserved bits read zero, run clear", int'(v), 32'h0000_ABCD);
    wr_reg(32'h8000_1234);
    rd_reg(v);
    chk("R1", "run bit stored", int'(v), 32'h8000_1234);
    reg_wdata = 32'h0000_5566;
    reg_wr = 1'b1;
    reg_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_rd = 1'b0;
    chk("R1", "read with write gives old word", int'(reg_rdata), 32'h8000_1234);
    rd_reg(v);
    chk("R1", "word after write", int'(v), 32'h0000_5566);
  endtask

  task automatic t_half_r1();
    int hi;
    wr_reg(32'h8000_0180);
    chk("R7", "high at first step", int'(pwm_out), 1);
    count_high(128, hi);
    chk("R4", "first 128 clocks high", hi, 128);
    count_high(128, hi);
    chk("R4", "last 128 clocks low", hi, 0);
    chk("R3", "next period starts high", int'(pwm_out), 1);
    stop_ch();
  endtask

  task automatic t_r3_half();
    int hi;
    wr_reg(32'h8000_0380);
    count_high(768, hi);
    chk("R3", "R=3 high clocks", hi, 384);
    chk("R3", "R=3 period boundary", int'(pwm_out), 1);
    stop_ch();
  endtask

  task automatic t_near_full();
    int hi;
    wr_reg(32'h8000_0201);
    count_high(510, hi);
    chk("R4", "N=1 R=2 high part", hi, 510);
    count_high(2, hi);
    chk("R4", "N=1 R=2 low part", hi, 0);
    stop_ch();
  endtask

  task automatic t_single_step();
    int hi;
    wr_reg(32'h8000_01FF);
    count_high(256, hi);
    chk("R4", "N=255 one high step", hi, 1);
    stop_ch();
  endtask

  task automatic t_zero_duty();
    int hi;
    wr_reg(32'h8000_0400);
    count_high(2048, hi);
    chk("R5", "N=0 stays low", hi, 0);
    stop_ch();
  endtask

  task automatic t_div256();
    int hi;
    wr_reg(32'h8000_00C0);
    count_high(65536, hi);
    chk("R3", "R=0 high clocks over 65536", hi, 16384);
    chk("R3", "R=0 period boundary", int'(pwm_out), 1);
    stop_ch();
  endtask

  task automatic t_disable();
    int hi;
    logic [31:0] v;
    wr_reg(32'h8000_0240);
    count_high(37, hi);
    wr_reg(32'h0000_0240);
    chk("R6", "low right after stop", int'(pwm_out), 0);
    count_high(300, hi);
    chk("R6", "low while stopped", hi, 0);
    rd_reg(v);
    chk("R6", "fields kept when stopped", int'(v), 32'h0000_0240);
    wr_reg(32'h8000_0240);
    chk("R7", "restart high at once", int'(pwm_out), 1);
    count_high(512, hi);
    chk("R7", "restart fresh period", hi, 384);
    stop_ch();
  endtask

  task automatic t_shadow();
    int hi;
    wr_reg(32'h8000_0180);
    count_high(50, hi);
    wr_reg(32'h8000_01C0);
    count_high(205, hi);
    chk("R8", "old duty holds to period end", hi, 77);
    @(negedge clk);
    count_high(256, hi);
    chk("R8", "new duty in next period", hi, 64);
    stop_ch();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    stop_ch();
    t_half_r1();
    t_r3_half();
    t_near_full();
    t_single_step();
    t_zero_duty();
    t_disable();
    t_shadow();
    t_div256();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule